// File: doc/BRIEF.md
# Raster Timing Generator with Key-Locked Configuration

This block generates the horizontal and vertical timing of a display raster. Two down-counters drive it. The horizontal counter steps once per clock. The vertical counter steps once per horizontal wrap. Each counter reloads from its programmed total when it reaches zero.

Eight window registers, four per axis, decode the counters into sync, blanking, active-video and pixel-clock-gate windows. Each window register holds a start count in its low half and a stop count in its high half. Because the counters run downwards, a window begins at its start count and ends just above its stop count.

A simple CPU register bus programs the block. Every configuration register is protected by a key lock. The key 0xAA, written to the lock register, opens the protected registers for exactly one following bus access. That access, whether a read or a write, closes the lock again. Software therefore writes the key before each protected write.

The counters run while the enable bit of the attribute register is set. The counter width is a parameter. The default of 12 bits covers rasters from 64x64 up to 1024x768 together with their porches and sync widths.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset every register reads 0, the lock is closed (lock register reads 0), and all raster outputs are low.
- R2: A write to any address other than the lock address (0) while the lock is closed is dropped: the target register keeps its old value and the raster is unaffected.
- R3: Writing 0x000000AA to address 0 opens the lock for exactly the next bus access (read or write, any address), which closes it again; a read of address 0 returns the lock state in bit 0, and that read itself consumes an open lock.
- R4: While enabled, the horizontal counter counts down by one per clock from the horizontal total (address 3) to 0 and then reloads the total.
- R5: The vertical counter counts down by one only in a clock where the horizontal counter is 0; from 0 it reloads the vertical total (address 4).
- R6: A window register holds its start count in bits [15:0] and its stop count in bits [31:16]; its window is true when stop < counter <= start. hsync, hblank, vsync and vblank follow the windows at addresses 5, 6, 9 and 10, and each output reflects the counters one clock later.
- R7: The active-video output is the AND of the horizontal active window (address 7) and the vertical active window (address 11). The pixel-clock gate output is the AND of the gate windows at addresses 8 and 12. Both are registered like R6.
- R8: The end-of-frame output pulses high for one clock, one clock after a cycle in which both counters are 0 while enabled.
- R9: Bit 0 of the attribute register (address 1) is the enable. While it is 0, both counters are held at their totals and every raster output is low.
- R10: Read data is registered and appears the clock after the read strobe. Address 2 is a plain protected storage register. Addresses 13 and above read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| hsync_o | output | 1 | Horizontal sync window |
| vsync_o | output | 1 | Vertical sync window |
| hblank_o | output | 1 | Horizontal blank window |
| vblank_o | output | 1 | Vertical blank window |
| active_o | output | 1 | Active video (both active windows) |
| pclk_gate_o | output | 1 | Pixel clock gate (both gate windows) |
| eof_o | output | 1 | One-clock end-of-frame pulse |

## Verification
The bench sweeps sync, back-porch and front-porch widths on both axes. It compares every output on every clock against a counter-and-window model driven only by the bus traffic it observes. This catches an off-by-one window edge, which would stretch or shorten sync by a clock, and a vertical counter that steps on the wrong horizontal count, which would skew every line's vsync.

The lock gets the most attention. A lock that stays open for a second access, that a read does not close, or that honours a locked write would each leave a register value that the bench reads back and flags.

The bench also drops an enable-clear while the raster runs. It counts end-of-frame pulses across whole frames, which shows a missing pulse or a doubled one.

// File: rtl/raster_pkg.sv
package raster_pkg;
  // register word addresses; the lock key is only honoured at ADR_LOCK
  localparam int ADR_LOCK   = 0;
  localparam int ADR_ATTR   = 1;
  localparam int ADR_CARRY  = 2;
  localparam int ADR_HTOTAL = 3;
  localparam int ADR_VTOTAL = 4;
  localparam int ADR_HWIN0  = 5;   // hsync, hblank, hactive, hgate
  localparam int ADR_VWIN0  = 9;   // vsync, vblank, vactive, vgate
  localparam int NUM_REGS   = 13;
  localparam int NUM_WIN    = 4;
  localparam logic [31:0] UNLOCK_KEY = 32'h0000_00AA;

  typedef enum int {
    WIN_SYNC   = 0,
    WIN_BLANK  = 1,
    WIN_ACTIVE = 2,
    WIN_GATE   = 3
  } win_kind_e;
endpackage

// File: rtl/raster_regs.sv
module raster_regs
  import raster_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              unlocked_o,
  output logic              enable_o,
  output logic [CNT_W-1:0]  htotal_o,
  output logic [CNT_W-1:0]  vtotal_o,
  output logic [CNT_W-1:0]  hstart_o [NUM_WIN],
  output logic [CNT_W-1:0]  hstop_o  [NUM_WIN],
  output logic [CNT_W-1:0]  vstart_o [NUM_WIN],
  output logic [CNT_W-1:0]  vstop_o  [NUM_WIN]
);
  localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(ADR_LOCK);
  localparam int STOP_LSB = 16;

  logic [31:0] regs [NUM_REGS];
  logic        unlocked_q;
  logic        addr_ok;
  logic        is_lock;
  logic        key_hit;

  assign addr_ok = int'(bus_addr) < NUM_REGS;
  assign is_lock = bus_addr == LOCK_A;
  assign key_hit = bus_wr && is_lock && (bus_wdata == UNLOCK_KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      unlocked_q <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      if (bus_wr && unlocked_q && !is_lock && addr_ok)
        regs[bus_addr] <= bus_wdata;
      if (bus_wr || bus_rd)
        unlocked_q <= key_hit;
      if (bus_rd) begin
        if (is_lock)      bus_rdata <= {31'b0, unlocked_q};
        else if (addr_ok) bus_rdata <= regs[bus_addr];
        else              bus_rdata <= '0;
      end
    end
  end

  assign unlocked_o = unlocked_q;
  assign enable_o   = regs[ADR_ATTR][0];
  assign htotal_o   = regs[ADR_HTOTAL][CNT_W-1:0];
  assign vtotal_o   = regs[ADR_VTOTAL][CNT_W-1:0];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win_fields
    assign hstart_o[w] = regs[ADR_HWIN0+w][CNT_W-1:0];
    assign hstop_o[w]  = regs[ADR_HWIN0+w][STOP_LSB+CNT_W-1:STOP_LSB];
    assign vstart_o[w] = regs[ADR_VWIN0+w][CNT_W-1:0];
    assign vstop_o[w]  = regs[ADR_VWIN0+w][STOP_LSB+CNT_W-1:STOP_LSB];
  end
endmodule

// File: rtl/raster_counter.sv
module raster_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             step,
  input  logic [CNT_W-1:0] total,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = run && step && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)            cnt_q <= '0;
    else if (!run)      cnt_q <= total;
    else if (step) begin
      if (cnt_q == '0)  cnt_q <= total;
      else              cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/raster_window.sv
module raster_window #(
  parameter int CNT_W = 12
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] start,
  input  logic [CNT_W-1:0] stop,
  output logic             hit_o
);
  // counters run downwards: window opens at start, closes above stop
  assign hit_o = (cnt <= start) && (cnt > stop);
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              hblank_o,
  output logic              vblank_o,
  output logic              active_o,
  output logic              pclk_gate_o,
  output logic              eof_o
);
  logic             unlocked;
  logic             en;
  logic [CNT_W-1:0] htotal, vtotal;
  logic [CNT_W-1:0] hstart [NUM_WIN];
  logic [CNT_W-1:0] hstop  [NUM_WIN];
  logic [CNT_W-1:0] vstart [NUM_WIN];
  logic [CNT_W-1:0] vstop  [NUM_WIN];
  logic [CNT_W-1:0] hcnt, vcnt;
  logic             h_wrap, v_wrap;
  logic [NUM_WIN-1:0] hhit, vhit;

  raster_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .unlocked_o(unlocked), .enable_o(en),
    .htotal_o(htotal), .vtotal_o(vtotal),
    .hstart_o(hstart), .hstop_o(hstop),
    .vstart_o(vstart), .vstop_o(vstop)
  );

  raster_counter #(.CNT_W(CNT_W)) u_hcnt (
    .clk(clk), .rst(rst), .run(en), .step(1'b1),
    .total(htotal), .cnt_o(hcnt), .wrap_o(h_wrap)
  );

  raster_counter #(.CNT_W(CNT_W)) u_vcnt (
    .clk(clk), .rst(rst), .run(en), .step(h_wrap),
    .total(vtotal), .cnt_o(vcnt), .wrap_o(v_wrap)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_windows
    raster_window #(.CNT_W(CNT_W)) u_hwin (
      .cnt(hcnt), .start(hstart[w]), .stop(hstop[w]), .hit_o(hhit[w])
    );
    raster_window #(.CNT_W(CNT_W)) u_vwin (
      .cnt(vcnt), .start(vstart[w]), .stop(vstop[w]), .hit_o(vhit[w])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o     <= 1'b0;
      vsync_o     <= 1'b0;
      hblank_o    <= 1'b0;
      vblank_o    <= 1'b0;
      active_o    <= 1'b0;
      pclk_gate_o <= 1'b0;
      eof_o       <= 1'b0;
    end else begin
      hsync_o     <= en && hhit[WIN_SYNC];
      vsync_o     <= en && vhit[WIN_SYNC];
      hblank_o    <= en && hhit[WIN_BLANK];
      vblank_o    <= en && vhit[WIN_BLANK];
      active_o    <= en && hhit[WIN_ACTIVE] && vhit[WIN_ACTIVE];
      pclk_gate_o <= en && hhit[WIN_GATE] && vhit[WIN_GATE];
      eof_o       <= v_wrap;
    end
  end
endmodule

// File: rtl/raster_timing_gen_chk.sv
module raster_timing_gen_chk #(
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              unlocked,
  input logic              en,
  input logic [CNT_W-1:0]  hcnt,
  input logic [CNT_W-1:0]  vcnt,
  input logic [CNT_W-1:0]  htotal,
  input logic              hsync_o,
  input logic              vsync_o,
  input logic              hblank_o,
  input logic              vblank_o,
  input logic              active_o,
  input logic              pclk_gate_o,
  input logic              eof_o
);
  localparam logic [ADDR_W-1:0] LOCK_A = '0;
  localparam logic [ADDR_W-1:0] HTOT_A = ADDR_W'(3);

  assert_locked_drop_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !unlocked && bus_addr == HTOT_A) |=> $stable(htotal));

  assert_key_opens_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == LOCK_A && bus_wdata == 32'hAA) |=> unlocked);

  assert_single_access_R3: assert property (@(posedge clk) disable iff (rst)
    (unlocked && (bus_wr || bus_rd) &&
     !(bus_wr && bus_addr == LOCK_A && bus_wdata == 32'hAA)) |=> !unlocked);

  assert_hstep_R4: assert property (@(posedge clk) disable iff (rst)
    (en && hcnt != '0) |=> (hcnt == $past(hcnt) - 1'b1));

  assert_vhold_R5: assert property (@(posedge clk) disable iff (rst)
    (en && hcnt != '0) |=> $stable(vcnt));

  assert_eof_single_R8: assert property (@(posedge clk) disable iff (rst)
    (eof_o && htotal != '0) |=> !eof_o);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !en |=> !(hsync_o || vsync_o || hblank_o || vblank_o ||
              active_o || pclk_gate_o || eof_o));
endmodule

bind raster_timing_gen raster_timing_gen_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .unlocked(unlocked),
  .en(en), .hcnt(hcnt), .vcnt(vcnt), .htotal(htotal),
  .hsync_o(hsync_o), .vsync_o(vsync_o), .hblank_o(hblank_o),
  .vblank_o(vblank_o), .active_o(active_o), .pclk_gate_o(pclk_gate_o),
  .eof_o(eof_o)
);

// File: tb/raster_timing_gen_test.sv
`timescale 1ns/1ps
module raster_timing_gen_test;
  localparam int ADDR_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0;
  logic bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic hsync_o, vsync_o, hblank_o, vblank_o, active_o, pclk_gate_o, eof_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  raster_timing_gen #(.CNT_W(12), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .hblank_o(hblank_o),
    .vblank_o(vblank_o), .active_o(active_o), .pclk_gate_o(pclk_gate_o),
    .eof_o(eof_o)
  );

  // ---------------- reference model, fed from observed bus traffic
  logic [31:0] m_regs [16];
  int  m_h, m_v;
  bit  m_unl;
  bit  e_hs, e_vs, e_hb, e_vb, e_act, e_gate, e_eof;
  bit  m_en;
  int  m_ht, m_vt;

  function automatic bit winf(input int cnt, input logic [31:0] r);
    return (cnt <= int'(r[11:0])) && (cnt > int'(r[27:16]));
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) m_regs[i] <= '0;
      m_h <= 0; m_v <= 0; m_unl <= 1'b0;
      e_hs <= 0; e_vs <= 0; e_hb <= 0; e_vb <= 0;
      e_act <= 0; e_gate <= 0; e_eof <= 0;
    end else begin
      m_en = m_regs[1][0];
      m_ht = int'(m_regs[3][11:0]);
      m_vt = int'(m_regs[4][11:0]);
      e_hs   <= m_en && winf(m_h, m_regs[5]);
      e_hb   <= m_en && winf(m_h, m_regs[6]);
      e_vs   <= m_en && winf(m_v, m_regs[9]);
      e_vb   <= m_en && winf(m_v, m_regs[10]);
      e_act  <= m_en && winf(m_h, m_regs[7]) && winf(m_v, m_regs[11]);
      e_gate <= m_en && winf(m_h, m_regs[8]) && winf(m_v, m_regs[12]);
      e_eof  <= m_en && m_h == 0 && m_v == 0;
      if (!m_en) begin
        m_h <= m_ht; m_v <= m_vt;
      end else begin
        m_h <= (m_h == 0) ? m_ht : m_h - 1;
        if (m_h == 0) m_v <= (m_v == 0) ? m_vt : m_v - 1;
      end
      if (bus_wr || bus_rd) begin
        if (bus_wr && m_unl && bus_addr != 0 && int'(bus_addr) < 13)
          m_regs[bus_addr] <= bus_wdata;
        m_unl <= bus_wr && bus_addr == 0 && bus_wdata == 32'hAA;
      end
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // cycle-by-cycle compare of all raster outputs against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R6", "hsync",  hsync_o,     e_hs);
      chk("R6", "vsync",  vsync_o,     e_vs);
      chk("R6", "hblank", hblank_o,    e_hb);
      chk("R6", "vblank", vblank_o,    e_vb);
      chk("R7", "active", active_o,    e_act);
      chk("R7", "gate",   pclk_gate_o, e_gate);
      chk("R8", "eof",    eof_o,       e_eof);
    end
  end

  // ---------------- bus tasks (entered at a negedge)
  task automatic bus_write(input int a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic prot_write(input int a, input logic [31:0] d);
    bus_write(0, 32'hAA);
    bus_write(a, d);
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = ADDR_W'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] wv(input int start, input int stop);
    return {stop[15:0], start[15:0]};
  endfunction

  int frame_len;

  task automatic program_cfg(input int ha, input int hfp, input int hbp, input int hs,
                             input int va, input int vfp, input int vbp, input int vs);
    int ht, vt;
    ht = ha + hfp + hbp + hs - 1;
    vt = va + vfp + vbp + vs - 1;
    prot_write(3, ht);
    prot_write(4, vt);
    prot_write(5,  wv(ht, ht - hs));
    prot_write(6,  wv(ht - hs - hbp, hfp - 1));
    prot_write(7,  wv(ht - hs - hbp, hfp - 1));
    prot_write(8,  wv(ht, hfp));
    prot_write(9,  wv(vt, vt - vs));
    prot_write(10, wv(vt - vs - vbp, vfp - 1));
    prot_write(11, wv(vt - vs - vbp, vfp - 1));
    prot_write(12, wv(vt, 0));
    frame_len = (ht + 1) * (vt + 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int eofs;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1", "outputs low", {hsync_o, vsync_o, hblank_o, vblank_o, active_o, pclk_gate_o, eof_o}, 0);
    bus_read(0, rd); chk("R1", "lock state", rd, 0);
    bus_read(1, rd); chk("R1", "attr", rd, 0);
    bus_read(3, rd); chk("R1", "htotal", rd, 0);

    // R2: locked write dropped
    bus_write(3, 32'd9);
    bus_read(3, rd); chk("R2", "locked htotal write", rd, 0);

    // R3: key then write lands
    prot_write(3, 32'd9);
    bus_read(3, rd); chk("R3", "unlocked htotal write", rd, 9);

    // R3: key consumed by a read
    bus_write(0, 32'hAA);
    bus_read(0, rd); chk("R3", "lock reads open", rd, 1);
    bus_read(0, rd); chk("R3", "read relocked", rd, 0);
    bus_write(0, 32'hAA);
    bus_read(3, rd); chk("R3", "read after key", rd, 9);
    bus_write(4, 32'd7);
    bus_read(4, rd); chk("R3", "second access dropped", rd, 0);

    // R3: wrong key closes
    bus_write(0, 32'hAA);
    bus_write(0, 32'h55);
    bus_write(4, 32'd7);
    bus_read(4, rd); chk("R3", "wrong key relocks", rd, 0);

    // R10: plain storage, out-of-range addresses
    prot_write(2, 32'hDEAD_BEEF);
    bus_read(2, rd); chk("R10", "carry storage", rd, 32'hDEAD_BEEF);
    prot_write(14, 32'h1234);
    bus_read(14, rd); chk("R10", "unmapped read", rd, 0);

    // R4 R5 R6 R7 R8 R9: sweep porch and sync widths
    for (int hs = 1; hs <= 2; hs++)
      for (int hbp = 1; hbp <= 2; hbp++)
        for (int hfp = 1; hfp <= 3; hfp++) begin
          program_cfg(3, hfp, hbp, hs, 2, 1 + (hfp % 2), 1 + (hs % 2), hbp);
          prot_write(1, 32'd1);
          eofs = 0;
          for (int c = 0; c < 2 * frame_len; c++) begin
            @(negedge clk);
            if (eof_o) eofs++;
          end
          chk("R8", "eof count over two frames", eofs, 2);
          // R2: locked disable attempt while running is dropped
          bus_write(1, 32'd0);
          bus_read(1, rd); chk("R2", "attr kept while running", rd, 1);
          repeat (5) @(negedge clk);
          prot_write(1, 32'd0);
          repeat (2) @(negedge clk);
          chk("R9", "outputs low when disabled",
              {hsync_o, vsync_o, hblank_o, vblank_o, active_o, pclk_gate_o, eof_o}, 0);
        end

    // R4 R5: mid-frame disable and re-enable restarts cleanly
    program_cfg(4, 2, 2, 2, 3, 1, 1, 1);
    prot_write(1, 32'd1);
    repeat (frame_len / 2) @(negedge clk);
    prot_write(1, 32'd0);
    prot_write(1, 32'd1);
    repeat (2 * frame_len) @(negedge clk);
    prot_write(1, 32'd0);
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule